// File: doc/BRIEF.md
# BPSK Modulator with Pseudo-Random Data Source

This block produces a binary phase-modulated carrier for a DAC running at a 100 MHz sample clock. A 7-bit maximal-length shift register generates the data. Each data bit becomes a polar value of +1 or -1, and that value multiplies a sine carrier read from a table. The carrier is 5 MHz, so one carrier cycle is 20 samples. The output is a signed 14-bit two's-complement sample stream.

One bit lasts a whole number of carrier cycles. The default is 4 cycles, or 80 samples. Because of this, every bit change falls on a carrier zero crossing, and the phase jumps by exactly half a turn there. A clock enable pauses the whole block: while the enable is low, the state holds and the output is held at zero. A synchronous reset restarts the data source, the polar mapping and the carrier phase together. The reset can load a seed given at an input.

Top module: `bpsk_prbs_mod`

## Requirements
- R1: A reset cycle loads the seed, sets the carrier phase to sample 0 and starts a new bit. On the first enabled cycle after reset, `strobe_o` is 1, `sample_o` is 0 and `bit_o` equals bit 6 of the loaded seed.
- R2: The carrier repeats every 20 enabled samples. Sample k of a cycle (k = 0..19) has magnitude round(8191 * sin(2*pi*k/20)).
- R3: A data bit of 1 sends the carrier with its sign as in R2. A data bit of 0 sends the negated carrier.
- R4: Each bit lasts 20 * CYCLES_PER_BIT enabled samples (80 by default). `strobe_o` is 1 exactly on the first sample of each bit. `bit_o` changes only at that point, where the carrier phase is sample 0.
- R5: The data register shifts left once per bit. The new bit 0 is bit 6 XOR bit 5 (polynomial x^7+x^6+1). The sent bit is bit 6, so the bit sequence repeats every 127 bits.
- R6: An all-zero seed is replaced by the default seed 7'h01.
- R7: While `en` is low, `sample_o` is 0, `strobe_o` is 0, and data, phase and bit position all hold. When `en` returns high, the stream continues from the same sample.
- R8: `sample_o` never takes the value -8192; its magnitude stays at or below 8191.
- R9: Where consecutive bits differ, each sample of the new bit is the negation of the sample at the same phase in the previous bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sample clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; low pauses the block and zeroes the output |
| seed_i | input | 7 | Seed loaded during reset; zero selects the default |
| sample_o | output | 14 | Signed modulated sample |
| bit_o | output | 1 | Data bit currently being sent |
| strobe_o | output | 1 | High on the first sample of each bit |

## Verification
The hardest situation to reach from the ports is a pause that falls in the middle of a bit: the block must hold its phase and bit position, then resume with no skipped or repeated sample. The bench drops the enable 50 samples into a bit for 33 cycles, which is not a multiple of the carrier period. It then tracks the resumed stream sample by sample against a model that counts only enabled cycles. The full 127-bit period of the data source is also run, so the repeat of the sequence and a phase reversal at a real bit change are both observed at the output.

// File: rtl/bpsk_prbs_mod.sv
module bpsk_prbs_mod #(
  parameter int SAMPLE_W = 14,
  parameter int CYCLES_PER_BIT = 4,
  parameter logic [6:0] DEFAULT_SEED = 7'h01
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic [6:0]                 seed_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       bit_o,
  output logic                       strobe_o
);
  localparam int PHASES = 20;
  localparam int CYC_W  = (CYCLES_PER_BIT > 1) ? $clog2(CYCLES_PER_BIT) : 1;
  localparam int AMP    = (1 << (SAMPLE_W - 1)) - 1;
  localparam int Q1 = int'(real'(AMP) * 0.3090169944);
  localparam int Q2 = int'(real'(AMP) * 0.5877852523);
  localparam int Q3 = int'(real'(AMP) * 0.8090169944);
  localparam int Q4 = int'(real'(AMP) * 0.9510565163);

  logic [6:0]       lfsr_q;
  logic [4:0]       ph_q;
  logic [CYC_W-1:0] cyc_q;

  wire last_ph  = (ph_q == 5'(PHASES - 1));
  wire last_cyc = (cyc_q == CYC_W'(CYCLES_PER_BIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= (seed_i == '0) ? DEFAULT_SEED : seed_i;
      ph_q   <= '0;
      cyc_q  <= '0;
    end else if (en) begin
      ph_q <= last_ph ? 5'd0 : ph_q + 5'd1;
      if (last_ph)
        cyc_q <= last_cyc ? '0 : cyc_q + 1'b1;
      if (last_ph && last_cyc)
        lfsr_q <= {lfsr_q[5:0], lfsr_q[6] ^ lfsr_q[5]};
    end
  end

  wire       neg_half = (ph_q >= 5'd10);
  wire [4:0] fold     = neg_half ? ph_q - 5'd10 : ph_q;
  wire [4:0] quad     = (fold > 5'd5) ? 5'd10 - fold : fold;

  logic signed [SAMPLE_W-1:0] mag;
  always_comb begin
    case (quad)
      5'd1:    mag = SAMPLE_W'(Q1);
      5'd2:    mag = SAMPLE_W'(Q2);
      5'd3:    mag = SAMPLE_W'(Q3);
      5'd4:    mag = SAMPLE_W'(Q4);
      5'd5:    mag = SAMPLE_W'(AMP);
      default: mag = '0;
    endcase
  end

  assign bit_o    = lfsr_q[6];
  assign strobe_o = en && (ph_q == 5'd0) && (cyc_q == '0);
  assign sample_o = !en ? '0 : ((bit_o ^ neg_half) ? mag : -mag);
endmodule

// File: rtl/bpsk_prbs_mod_chk.sv
module bpsk_prbs_mod_chk #(
  parameter int SAMPLE_W = 14
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       en,
  input logic signed [SAMPLE_W-1:0] sample_o,
  input logic                       bit_o,
  input logic                       strobe_o,
  input logic [4:0]                 ph_q
);
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |-> (sample_o == '0 && !strobe_o));

  a_r7_hold_bit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> $stable(bit_o));

  a_r4_bit_edge: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && en && bit_o != $past(bit_o)) |-> strobe_o);

  a_r4_strobe_zero: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (sample_o == '0));

  a_r8_range: assert property (@(posedge clk) disable iff (rst)
    sample_o != MOST_NEG);

  a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
    ph_q < 5'd20);
endmodule

bind bpsk_prbs_mod bpsk_prbs_mod_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .sample_o(sample_o),
  .bit_o(bit_o), .strobe_o(strobe_o), .ph_q(ph_q)
);

// File: tb/bpsk_prbs_mod_bench.sv
`timescale 1ns/1ps
module bpsk_prbs_mod_bench;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic [6:0]        seed_i = 7'h00;
  logic signed [13:0] sample_o;
  logic              bit_o, strobe_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [6:0] m_lfsr;
  int n;

  always #5 clk = ~clk;

  bpsk_prbs_mod u_bpsk_prbs_mod (
    .clk(clk), .rst(rst), .en(en), .seed_i(seed_i),
    .sample_o(sample_o), .bit_o(bit_o), .strobe_o(strobe_o)
  );

  function automatic int carrier(int k);
    real x;
    x = 8191.0 * $sin(2.0 * 3.14159265358979 * k / 20.0);
    return $rtoi(x >= 0.0 ? x + 0.5 : x - 0.5);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [6:0] s);
    @(negedge clk);
    rst = 1'b1; en = 1'b1; seed_i = s;
    @(negedge clk);
    rst = 1'b0;
    m_lfsr = (s == 7'h00) ? 7'h01 : s;
    n = 0;
  endtask

  // compare current outputs to the model, then advance one clock
  task automatic step(string tag);
    int c, es;
    c  = carrier(n % 20);
    es = en ? (m_lfsr[6] ? c : -c) : 0;
    chk({tag, " R2/R3 sample"}, int'(sample_o), es);
    chk({tag, " R4 strobe"}, int'(strobe_o), int'(en && (n % 80 == 0)));
    chk({tag, " R5 bit"}, int'(bit_o), int'(m_lfsr[6]));
    chk({tag, " R8 range"}, int'(sample_o != -14'sd8192), 1);
    if (en) begin
      if (n % 80 == 79) m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
      n++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(7'h45);
    chk("R1 strobe after reset", int'(strobe_o), 1);
    chk("R1 sample after reset", int'(sample_o), 0);
    chk("R1 bit equals seed bit 6", int'(bit_o), 1);
  endtask

  task automatic t_stream();
    do_reset(7'h2B);
    for (int i = 0; i < 12 * 80; i++) step("stream");
    chk("R2 peak sample", carrier(5), 8191);
  endtask

  task automatic t_period();
    logic b [0:133];
    int idx;
    int ones;
    do_reset(7'h45);
    idx = 0; ones = 0;
    for (int i = 0; i < 134 * 80; i++) begin
      if (strobe_o) begin
        b[idx] = bit_o;
        ones += int'(bit_o);
        idx++;
      end
      step("period");
    end
    chk("R5 strobes per period run", idx, 134);
    for (int i = 0; i < 7; i++)
      chk("R5 sequence repeats after 127 bits", int'(b[i + 127]), int'(b[i]));
    chk("R5 ones in one period window", ones > 0 && ones < 134 ? 1 : 0, 1);
  endtask

  task automatic t_zero_seed();
    do_reset(7'h00);
    for (int i = 0; i < 6 * 80; i++) begin
      if (strobe_o) chk("R6 default seed leading zero", int'(bit_o), 0);
      step("zero seed R6");
    end
    chk("R6 seventh bit is one", int'(bit_o), 1);
    for (int i = 0; i < 8 * 80; i++) step("zero seed R6");
  endtask

  task automatic t_enable();
    logic held_bit;
    do_reset(7'h5C);
    for (int i = 0; i < 50; i++) step("pre-pause");
    held_bit = bit_o;
    en = 1'b0;
    for (int i = 0; i < 33; i++) begin
      chk("R7 paused sample zero", int'(sample_o), 0);
      chk("R7 paused strobe low", int'(strobe_o), 0);
      chk("R7 paused bit held", int'(bit_o), int'(held_bit));
      step("pause R7");
    end
    en = 1'b1;
    for (int i = 0; i < 3 * 80; i++) step("resume R7");
  endtask

  task automatic t_flip();
    int s5, s85, s25;
    do_reset(7'h40);
    for (int i = 0; i < 100; i++) begin
      if (n == 5)  s5  = int'(sample_o);
      if (n == 25) s25 = int'(sample_o);
      if (n == 85) s85 = int'(sample_o);
      step("flip");
    end
    chk("R9 reversed phase after bit change", s85, -s5);
    chk("R9 reversed value is nonzero", s85, -8191);
    chk("R2 carrier period is 20 samples", s25, s5);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stream();
    t_zero_seed();
    t_enable();
    t_flip();
    t_period();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule